// File: doc/BRIEF.md
# Dual PWM Gain-Control Driver

This block turns a signed level-error stream from a receiver's power detector into two pulse-width-modulated gain-control bit streams. One stream controls the tuner and the other controls the IF stage. Each stream is meant to be smoothed by an external RC network. Every accepted error sample is one symbol. It is added into a saturating gain integrator.

On every 1024th accepted symbol the integrator's gain word is split between the two outputs at a programmable take-over threshold, and the two duty values are latched. While the gain sits below the threshold, only the IF duty moves and the tuner stays at full duty. Above the threshold, the IF duty stays pinned at the threshold and the tuner duty falls as the gain rises.

A control input can replace the IF duty with a fixed programmed value. Both outputs also come with an open-drain style drive-low enable.

The error input is a valid/ready stream. `err_ready` is permanently high, so the block never applies back-pressure and a sample is taken on every clock where `err_valid` is high. The threshold and override inputs are plain control pins. They are sampled at the moment a refresh latches new duties.

Top module: `gain_pwm_pair`

## Requirements
- R1: After reset the tuner duty is 255 and the IF duty is 0, so the IF output stays low, and `err_ready` is high.
- R2: Each output repeats a frame of 256 slots, each 16 clocks long. The output is high during the first D slots of each frame, where D is the 8-bit duty, so any 4096 consecutive clocks contain exactly 16*D high clocks.
- R3: Neither output changes level less than 16 clocks after its previous change.
- R4: Each accepted symbol adds `err_data` to a 16-bit unsigned accumulator. `err_data` is read as an 8-bit two's-complement value. The result saturates at 0 and at 65535 instead of wrapping.
- R5: The gain g is accumulator bits [15:7], giving a range of 0 to 511. If g is less than the threshold T, the IF duty is g and the tuner duty is 255. Otherwise the IF duty is T and the tuner duty is 255-(g-T), with a floor of 0.
- R6: Duties are latched only on every 1024th accepted symbol, using the accumulator value that includes that symbol. A newly latched duty takes effect at the start of the next PWM frame. Symbols that do not complete a 1024-symbol group leave both outputs unchanged.
- R7: When `if_fixed_en` is high at a latch, the IF duty becomes `if_fixed_duty` and the tuner duty follows R5. The latched IF duty is kept until the next latch, even if `if_fixed_en` changes in between.
- R8: Each drive-low output is high exactly when its PWM output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_valid | input | 1 | Error sample valid; one symbol per accepted sample |
| err_ready | output | 1 | Always high; no back-pressure |
| err_data | input | 8 | Signed level error, two's complement |
| takeover_thr | input | 8 | Take-over threshold T |
| if_fixed_en | input | 1 | Select fixed IF duty at the next latch |
| if_fixed_duty | input | 8 | Fixed IF duty value |
| tun_pwm | output | 1 | Tuner PWM level |
| tun_drv_low | output | 1 | Tuner open-drain pull-down enable |
| if_pwm | output | 1 | IF PWM level |
| if_drv_low | output | 1 | IF open-drain pull-down enable |

## Verification
The assertions assume that `takeover_thr`, `if_fixed_en` and `if_fixed_duty` only matter in the cycle a refresh latches them. They also assume that any 8-bit pattern on `err_data` is legal, with a sample counted only when `err_valid` is high. The stimulus holds the control pins steady across each 1024-symbol group and drives errors only at the falling clock edge, with randomly gapped valid. It never sends symbols while it measures output duty, so the latched values stay constant over each full-frame window.

// File: rtl/gpwm_pkg.sv
package gpwm_pkg;
  localparam int NUM_CH   = 2;
  localparam int CH_TUNER = 0;
  localparam int CH_IF    = 1;
endpackage

// File: rtl/gpwm_integrator.sv
module gpwm_integrator #(
  parameter int ERR_W        = 8,
  parameter int ACC_W        = 16,
  parameter int GAIN_W       = 9,
  parameter int REFRESH_SYMS = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [ERR_W-1:0]  err,
  output logic [GAIN_W-1:0] gain_next,
  output logic              refresh
);
  localparam int CNT_W = $clog2(REFRESH_SYMS);
  localparam int SUM_W = ACC_W + 2;

  logic [ACC_W-1:0] acc_q, acc_next;
  logic [CNT_W-1:0] cnt_q;
  logic [SUM_W-1:0] sum;

  always_comb begin
    sum = {2'b00, acc_q} + {{(SUM_W-ERR_W){err[ERR_W-1]}}, err};
    if (!fire)             acc_next = acc_q;
    else if (sum[SUM_W-1]) acc_next = '0;
    else if (sum[ACC_W])   acc_next = '1;
    else                   acc_next = sum[ACC_W-1:0];
  end

  assign refresh   = fire && (cnt_q == CNT_W'(REFRESH_SYMS - 1));
  assign gain_next = acc_next[ACC_W-1 -: GAIN_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      acc_q <= acc_next;
      if (refresh)   cnt_q <= '0;
      else if (fire) cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_ACC_NO_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !err[ERR_W-1] |=> acc_q >= $past(acc_q)); // R4
  AST_ACC_NO_WRAP_DN: assert property (@(posedge clk) disable iff (!rst_n)
    fire && err[ERR_W-1] |=> acc_q <= $past(acc_q)); // R4
  AST_ACC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(acc_q)); // R4
endmodule

// File: rtl/gpwm_split.sv
module gpwm_split #(
  parameter int GAIN_W = 9,
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              refresh,
  input  logic [GAIN_W-1:0] gain,
  input  logic [DUTY_W-1:0] thr,
  input  logic              fixed_en,
  input  logic [DUTY_W-1:0] fixed_duty,
  output logic [DUTY_W-1:0] tun_lat,
  output logic [DUTY_W-1:0] if_lat
);
  localparam logic [DUTY_W-1:0] DMAX   = '1;
  localparam logic [GAIN_W-1:0] DMAX_G = GAIN_W'(DMAX);

  logic [GAIN_W-1:0] thr_g, diff;
  logic [DUTY_W-1:0] tun_calc, if_calc;

  always_comb begin
    thr_g = GAIN_W'(thr);
    diff  = gain - thr_g;
    if (gain < thr_g) begin
      if_calc  = gain[DUTY_W-1:0];
      tun_calc = DMAX;
    end else begin
      if_calc  = thr;
      tun_calc = (diff >= DMAX_G) ? '0 : DUTY_W'(DMAX_G - diff);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tun_lat <= DMAX;
      if_lat  <= '0;
    end else if (refresh) begin
      tun_lat <= tun_calc;
      if_lat  <= fixed_en ? fixed_duty : if_calc;
    end
  end

  AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !refresh |=> $stable(tun_lat) && $stable(if_lat)); // R6
  AST_TAKEOVER_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    refresh && !fixed_en |=> (tun_lat == DMAX) || (if_lat == $past(thr))); // R5
  AST_FIXED_IF: assert property (@(posedge clk) disable iff (!rst_n)
    refresh && fixed_en |=> if_lat == $past(fixed_duty)); // R7
endmodule

// File: rtl/gpwm_timebase.sv
module gpwm_timebase #(
  parameter int SLOT_CLKS = 16,
  parameter int DUTY_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [DUTY_W-1:0] slot,
  output logic              frame_start
);
  localparam int PRE_W = $clog2(SLOT_CLKS);

  logic [PRE_W-1:0] pre_q;
  logic             slot_tick;

  assign slot_tick   = (pre_q == PRE_W'(SLOT_CLKS - 1));
  assign frame_start = slot_tick && (slot == {DUTY_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
      slot  <= '0;
    end else if (slot_tick) begin
      pre_q <= '0;
      slot  <= slot + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_tick |=> $stable(slot)); // R2
endmodule

// File: rtl/gpwm_channel.sv
module gpwm_channel #(
  parameter int                 DUTY_W     = 8,
  parameter int                 SLOT_CLKS  = 16,
  parameter logic [DUTY_W-1:0]  RESET_DUTY = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DUTY_W-1:0] slot,
  input  logic              frame_start,
  input  logic [DUTY_W-1:0] duty_lat,
  output logic              pwm,
  output logic              drv_low
);
  localparam int RUN_W = $clog2(SLOT_CLKS) + 1;

  logic [DUTY_W-1:0] duty_app;

  always_ff @(posedge clk) begin
    if (!rst_n)           duty_app <= RESET_DUTY;
    else if (frame_start) duty_app <= duty_lat;
  end

  assign pwm     = (slot < duty_app);
  assign drv_low = !pwm;

  logic             pwm_d;
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwm_d <= (RESET_DUTY != '0);
      run_q <= RUN_W'(SLOT_CLKS);
    end else begin
      pwm_d <= pwm;
      if (pwm != pwm_d)                  run_q <= '0;
      else if (run_q < RUN_W'(SLOT_CLKS)) run_q <= run_q + 1'b1;
    end
  end

  AST_EDGE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm != pwm_d) |-> (run_q >= RUN_W'(SLOT_CLKS - 1))); // R3
  AST_FRAME_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(duty_app)); // R6
endmodule

// File: rtl/gain_pwm_pair.sv
module gain_pwm_pair #(
  parameter int ERR_W        = 8,
  parameter int ACC_W        = 16,
  parameter int DUTY_W       = 8,
  parameter int SLOT_CLKS    = 16,
  parameter int REFRESH_SYMS = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_valid,
  output logic              err_ready,
  input  logic [ERR_W-1:0]  err_data,
  input  logic [DUTY_W-1:0] takeover_thr,
  input  logic              if_fixed_en,
  input  logic [DUTY_W-1:0] if_fixed_duty,
  output logic              tun_pwm,
  output logic              tun_drv_low,
  output logic              if_pwm,
  output logic              if_drv_low
);
  import gpwm_pkg::*;

  localparam int GAIN_W = DUTY_W + 1;

  logic              fire, refresh, frame_start;
  logic [GAIN_W-1:0] gain_next;
  logic [DUTY_W-1:0] slot;
  logic [DUTY_W-1:0] duty_lat [NUM_CH];
  logic              pwm_v    [NUM_CH];
  logic              low_v    [NUM_CH];

  assign err_ready = 1'b1;
  assign fire      = err_valid && err_ready;

  gpwm_integrator #(.ERR_W(ERR_W), .ACC_W(ACC_W), .GAIN_W(GAIN_W),
                    .REFRESH_SYMS(REFRESH_SYMS)) u_integ (
    .clk(clk), .rst_n(rst_n), .fire(fire), .err(err_data),
    .gain_next(gain_next), .refresh(refresh));

  gpwm_split #(.GAIN_W(GAIN_W), .DUTY_W(DUTY_W)) u_split (
    .clk(clk), .rst_n(rst_n), .refresh(refresh), .gain(gain_next),
    .thr(takeover_thr), .fixed_en(if_fixed_en), .fixed_duty(if_fixed_duty),
    .tun_lat(duty_lat[CH_TUNER]), .if_lat(duty_lat[CH_IF]));

  gpwm_timebase #(.SLOT_CLKS(SLOT_CLKS), .DUTY_W(DUTY_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .slot(slot), .frame_start(frame_start));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam logic [DUTY_W-1:0] RST_D = (ch == CH_TUNER) ? '1 : '0;
    gpwm_channel #(.DUTY_W(DUTY_W), .SLOT_CLKS(SLOT_CLKS),
                   .RESET_DUTY(RST_D)) u_chan (
      .clk(clk), .rst_n(rst_n), .slot(slot), .frame_start(frame_start),
      .duty_lat(duty_lat[ch]), .pwm(pwm_v[ch]), .drv_low(low_v[ch]));
  end

  assign tun_pwm     = pwm_v[CH_TUNER];
  assign tun_drv_low = low_v[CH_TUNER];
  assign if_pwm      = pwm_v[CH_IF];
  assign if_drv_low  = low_v[CH_IF];
endmodule

// File: tb/gain_pwm_pair_bench.sv
module gain_pwm_pair_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic err_valid = 1'b0;
  logic err_ready;
  logic [7:0] err_data = '0;
  logic [7:0] takeover_thr = 8'd128;
  logic if_fixed_en = 1'b0;
  logic [7:0] if_fixed_duty = '0;
  logic tun_pwm, tun_drv_low, if_pwm, if_drv_low;

  always #5 clk = ~clk;

  gain_pwm_pair u_gain_pwm_pair (
    .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_ready(err_ready),
    .err_data(err_data), .takeover_thr(takeover_thr), .if_fixed_en(if_fixed_en),
    .if_fixed_duty(if_fixed_duty), .tun_pwm(tun_pwm), .tun_drv_low(tun_drv_low),
    .if_pwm(if_pwm), .if_drv_low(if_drv_low));

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int m_acc = 0;
  int m_cnt = 0;
  int exp_t = 255;
  int exp_i = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int split_tun(input int acc, input int thr);
    int g = acc >> 7;
    if (g < thr) return 255;
    return (g - thr >= 255) ? 0 : 255 - (g - thr);
  endfunction

  function automatic int split_if(input int acc, input int thr, input bit fen, input int fd);
    int g = acc >> 7;
    if (fen) return fd;
    return (g < thr) ? g : thr;
  endfunction

  // mode 0: fixed error value, mode 1: random error; pv = valid percentage
  task automatic send_syms(input int n, input bit mode, input int fixed_err, input int pv);
    int sent = 0;
    while (sent < n) begin
      logic signed [7:0] e;
      bit v;
      @(negedge clk);
      v = (($urandom % 100) < pv);
      e = mode ? 8'($urandom) : 8'(fixed_err);
      err_valid = v;
      err_data = e;
      if (v) begin
        sent++;
        m_acc = m_acc + int'(e);
        if (m_acc < 0) m_acc = 0;
        if (m_acc > 65535) m_acc = 65535;
        m_cnt++;
        if (m_cnt == 1024) begin
          m_cnt = 0;
          exp_t = split_tun(m_acc, int'(takeover_thr));
          exp_i = split_if(m_acc, int'(takeover_thr), if_fixed_en, int'(if_fixed_duty));
        end
      end
    end
    @(negedge clk);
    err_valid = 1'b0;
  endtask

  task automatic measure(input string tag);
    int th = 0, ih = 0, od_bad = 0, min_gap = 100000, last_t = -1, last_i = -1;
    bit pt, pi;
    repeat (4200) @(negedge clk);
    pt = tun_pwm; pi = if_pwm;
    for (int k = 0; k < 4096; k++) begin
      @(negedge clk);
      if (tun_pwm) th++;
      if (if_pwm) ih++;
      if (tun_drv_low == tun_pwm || if_drv_low == if_pwm) od_bad++;
      if (tun_pwm != pt) begin
        if (last_t >= 0 && k - last_t < min_gap) min_gap = k - last_t;
        last_t = k; pt = tun_pwm;
      end
      if (if_pwm != pi) begin
        if (last_i >= 0 && k - last_i < min_gap) min_gap = k - last_i;
        last_i = k; pi = if_pwm;
      end
    end
    check({"R2 R5 tuner duty ", tag}, th, exp_t * 16);
    check({"R2 R5 IF duty ", tag}, ih, exp_i * 16);
    check({"R8 drive-low ", tag}, od_bad, 0);
    check({"R3 edge spacing ", tag}, (min_gap >= 16) ? 1 : 0, 1);
  endtask

  initial begin
    repeat (1_000_000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 err_ready", int'(err_ready), 1);
    check("R1 IF low after reset", int'(if_pwm), 0);
    measure("R1 reset");
    // R5 boundary g == T
    send_syms(1024, 0, 16, 100);
    check("R5 model boundary", exp_t * 1000 + exp_i, 255128);
    measure("R5 g equals T");
    // R4 accumulate with gapped valid
    send_syms(1024, 0, 4, 50);
    measure("R4 accumulate");
    // R4 high saturation
    send_syms(1024, 0, 127, 100);
    check("R4 model saturation high", exp_t, 0);
    measure("R4 saturate high");
    // R6 incomplete group has no effect
    send_syms(1023, 0, -128, 80);
    measure("R6 partial group");
    send_syms(1, 0, 0, 100);
    measure("R6 group completes");
    // R4 low saturation: no wrap, climbs from zero
    send_syms(1024, 0, 8, 100);
    check("R4 model saturation low", exp_i, 64);
    measure("R4 saturate low");
    // R7 fixed IF duty
    if_fixed_en = 1'b1;
    if_fixed_duty = 8'd90;
    send_syms(1024, 0, 10, 100);
    measure("R7 fixed IF");
    if_fixed_en = 1'b0;
    measure("R7 held until latch");
    // random blocks
    for (int b = 0; b < 4; b++) begin
      takeover_thr = 8'($urandom);
      if_fixed_en = ($urandom % 4) == 0;
      if_fixed_duty = 8'($urandom);
      send_syms(1024, 1, 0, 60 + b * 10);
      measure("R4 R5 R7 random");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule